// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the byte address of the instruction being executed and chooses, every clock, the address of the next one. It looks at the 32-bit instruction word that belongs to the current address and at the two register values that a register file has already read for the two source fields of that word. From these it decides whether execution continues in sequence, follows a conditional branch that compares the two values, or goes to an absolute jump target.

A branch carries a signed 16-bit displacement counted in instructions. The unit scales that count to bytes and adds it to the address of the following instruction, not to the current one. A jump carries a 26-bit word index. The unit places that index under the upper four bits of the following instruction's address, so a jump stays inside the 256 MiB region that the next sequential address lies in. Alongside the address the block drives a redirect flag that tells fetch logic that the coming address is not the sequential one.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_now` becomes 0x00000000, and `redirect` is low for as long as `rst_n` is low.
- R2: When the instruction is not a taken branch or a jump, `pc_now` at the next edge equals its current value plus 4, modulo 2^32.
- R3: Opcode 4 (instruction bits 31:26) with `opnd_a` equal to `opnd_b` sets the next `pc_now` to (`pc_now` + 4) + 4 × the sign-extended value of bits 15:0.
- R4: Opcode 5 with `opnd_a` different from `opnd_b` sets the next `pc_now` to (`pc_now` + 4) + 4 × the sign-extended value of bits 15:0.
- R5: Opcode 4 with unequal operands, and opcode 5 with equal operands, give sequential flow and leave `redirect` low.
- R6: The branch displacement is two's complement: a set bit 15 moves the address backwards, with 0x8000 reaching -2^15 instructions and 0x7FFF reaching +2^15-1 instructions.
- R7: Opcode 2 sets the next `pc_now` to the upper 4 bits of (`pc_now` + 4), followed by instruction bits 25:0, followed by two zero bits, whatever the operand values.
- R8: Every opcode other than 2, 4 and 5 gives sequential flow and leaves `redirect` low, even when the operands are equal.
- R9: `redirect` is high in a cycle, out of reset, exactly when the current instruction is a jump or a taken branch, i.e. when the next `pc_now` is the redirected address.
- R10: The two low bits of `pc_now` are always 00.
- R11: Address arithmetic wraps modulo 2^32: a backward branch below address 0 lands near the top of the space, and a jump from there keeps region 0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_word | input | 32 | Instruction word held at the current address |
| opnd_a | input | 32 | Value read for the first source register field |
| opnd_b | input | 32 | Value read for the second source register field |
| pc_now | output | 32 | Current program counter (byte address) |
| redirect | output | 1 | Next address is a branch or jump target |

## Verification
The sequential increment and the jump target build meet in one cycle when a jump sits in the last word of a 256 MiB region: the carry out of the +4 decides which region the jump lands in. The bench places a jump at 0x0FFFFFFC and expects the target to take region 0x1. It also drives a backward branch from near address 0, so that the displacement adder and the wrap of the address space act in the same step, and then follows it with a jump that has to pick up region 0xF. Every cycle the bench model's next address and redirect value are compared with the ports, and random streams mix equal and unequal operands under every opcode class.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
// pcu_pkg: shared field layout, opcode values and flow kinds for the
// next-address unit. Assumes the opcode sits at the top of every word.
package pcu_pkg;

    localparam int INSTR_W    = 32;
    localparam int OPC_W      = 6;
    localparam int IMM_W      = 16;
    localparam int JFLD_W     = 26;
    localparam int BYTE_SHIFT = 2;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BREQ = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BRNE = 6'd5;

    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_BREQ = 2'd1,
        FLOW_BRNE = 2'd2,
        FLOW_JUMP = 2'd3
    } flow_e;

endpackage

// File: rtl/pcu_decode.sv
`timescale 1ns/1ps
// pcu_decode: splits the instruction word into a flow kind, the branch
// displacement field and the jump index field. Assumes the fields are
// fixed in position; unknown opcodes decode to sequential flow.
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output flow_e              flow,
    output logic [IMM_W-1:0]   imm,
    output logic [JFLD_W-1:0]  jfld
);

    logic [OPC_W-1:0] opc;

    assign opc  = instr[INSTR_W-1 -: OPC_W];
    assign imm  = instr[IMM_W-1:0];
    assign jfld = instr[JFLD_W-1:0];

    // Map the opcode onto the four flow kinds.
    always_comb begin
        case (opc)
            OPC_JUMP: flow = FLOW_JUMP;
            OPC_BREQ: flow = FLOW_BREQ;
            OPC_BRNE: flow = FLOW_BRNE;
            default:  flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/pcu_cond.sv
`timescale 1ns/1ps
// pcu_cond: decides whether the current instruction leaves sequential
// flow. Assumes the operands are already read for this instruction.
// XOR_CMP picks an XOR-reduce comparator instead of a plain equality.
module pcu_cond
    import pcu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit XOR_CMP = 1'b0
) (
    input  flow_e             flow,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              take
);

    logic same;

    generate
        if (XOR_CMP) begin : g_xor_cmp
            assign same = ~|(opnd_a ^ opnd_b);
        end else begin : g_eq_cmp
            assign same = (opnd_a == opnd_b);
        end
    endgenerate

    // Resolve the taken decision for each flow kind.
    always_comb begin
        case (flow)
            FLOW_JUMP: take = 1'b1;
            FLOW_BREQ: take = same;
            FLOW_BRNE: take = ~same;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
`timescale 1ns/1ps
// pcu_target: builds the next address from the current one. Assumes the
// current address is word aligned. SHARED_ADDER folds the sequential and
// branch sums into one adder chain instead of two parallel results.
module pcu_target
    import pcu_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic [ADDR_W-1:0] pc,
    input  flow_e             flow,
    input  logic              take,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JFLD_W-1:0] jfld,
    output logic [ADDR_W-1:0] pc_next
);

    localparam int REGION_W = ADDR_W - JFLD_W - BYTE_SHIFT;
    localparam int EXT_W    = ADDR_W - IMM_W - BYTE_SHIFT;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << BYTE_SHIFT);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_disp;
    logic [ADDR_W-1:0] jmp_addr;
    logic              is_jump;

    assign is_jump  = (flow == FLOW_JUMP);
    assign seq_addr = pc + STEP;
    assign br_disp  = {{EXT_W{imm[IMM_W-1]}}, imm, {BYTE_SHIFT{1'b0}}};
    assign jmp_addr = {seq_addr[ADDR_W-1 -: REGION_W], jfld, {BYTE_SHIFT{1'b0}}};

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [ADDR_W-1:0] addend;
            logic [ADDR_W-1:0] sum;
            // Zero the displacement unless a branch is taken.
            always_comb begin
                addend = (take && !is_jump) ? br_disp : '0;
            end
            assign sum = seq_addr + addend;
            // Jump target overrides the summed address.
            always_comb begin
                pc_next = (take && is_jump) ? jmp_addr : sum;
            end
        end else begin : g_parallel
            logic [ADDR_W-1:0] br_addr;
            assign br_addr = seq_addr + br_disp;
            // Pick one of three precomputed addresses.
            always_comb begin
                if (!take)
                    pc_next = seq_addr;
                else if (is_jump)
                    pc_next = jmp_addr;
                else
                    pc_next = br_addr;
            end
        end
    endgenerate

endmodule

// File: rtl/pcu_pc_reg.sv
`timescale 1ns/1ps
// pcu_pc_reg: the program counter register with synchronous active-low
// reset to RESET_ADDR. Assumes RESET_ADDR is word aligned.
module pcu_pc_reg #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Load the next address, or the reset address while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_ADDR;
        else
            q <= d;
    end

endmodule

// File: rtl/pc_next_unit.sv
`timescale 1ns/1ps
// pc_next_unit: program counter with next-address selection for
// sequential flow, equal/not-equal register branches and region jumps.
// Assumes instr_word is the word stored at pc_now and the operands are
// the values read for its two source fields in the same cycle.
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter bit XOR_CMP      = 1'b0,
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic [ADDR_W-1:0]  pc_now,
    output logic               redirect
);

    flow_e             flow;
    logic [IMM_W-1:0]  imm;
    logic [JFLD_W-1:0] jfld;
    logic              take;
    logic [ADDR_W-1:0] pc_next;

    pcu_decode u_decode (
        .instr (instr_word),
        .flow  (flow),
        .imm   (imm),
        .jfld  (jfld)
    );

    pcu_cond #(
        .DATA_W  (DATA_W),
        .XOR_CMP (XOR_CMP)
    ) u_cond (
        .flow   (flow),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .take   (take)
    );

    pcu_target #(
        .ADDR_W       (ADDR_W),
        .SHARED_ADDER (SHARED_ADDER)
    ) u_target (
        .pc      (pc_now),
        .flow    (flow),
        .take    (take),
        .imm     (imm),
        .jfld    (jfld),
        .pc_next (pc_next)
    );

    pcu_pc_reg #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR ('0)
    ) u_pc_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pc_next),
        .q     (pc_now)
    );

    // Redirect is meaningful only out of reset.
    assign redirect = take & rst_n;

endmodule

// File: rtl/pc_next_unit_chk.sv
`timescale 1ns/1ps
// pc_next_unit_chk: temporal properties of the next-address unit,
// attached to every instance of the top module.
module pc_next_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_word,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [ADDR_W-1:0] pc_now,
    input logic              redirect
);

    logic [5:0] opc;
    logic       special;
    logic [ADDR_W-1:0] disp;

    assign opc     = instr_word[31:26];
    assign special = (opc == 6'd2) || (opc == 6'd4) || (opc == 6'd5);
    assign disp    = {{(ADDR_W-18){instr_word[15]}}, instr_word[15:0], 2'b00};

    // R1: redirect stays low while reset is held
    always_comb begin
        if (rst_n === 1'b0)
            p_no_redirect_in_reset_r1: assert (redirect == 1'b0);
    end

    // R1: first cycle after reset shows address zero
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (pc_now == '0));

    // R10: word alignment
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_now[1:0] == 2'b00);

    // R2 R8: non-control opcodes step by four
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !special |=> (pc_now == $past(pc_now) + ADDR_W'(4)));

    // R8 R9: redirect only for control opcodes
    p_redirect_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> special);

    // R5: not-equal branch with equal operands falls through
    p_bne_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'd5 && opnd_a == opnd_b) |=>
            (pc_now == $past(pc_now) + ADDR_W'(4)));

    // R3: taken equal branch lands on the scaled displacement
    p_beq_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'd4 && opnd_a == opnd_b) |=>
            (pc_now == $past(pc_now) + ADDR_W'(4) + $past(disp)));

    // R7: jump keeps the index in the low address bits
    p_jump_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'd2) |=> (pc_now[27:0] == {$past(instr_word[25:0]), 2'b00}));

endmodule

bind pc_next_unit pc_next_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_word (instr_word),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .pc_now     (pc_now),
    .redirect   (redirect)
);

// File: tb/pc_next_unit_tb.sv
`timescale 1ns/1ps
// pc_next_unit_tb: behavioural next-address model checked every cycle.
module pc_next_unit_tb;

    logic        clk;
    logic        rst_n;
    logic [31:0] instr_word;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] pc_now;
    logic        redirect;

    int          n_checks;
    int          n_fails;
    logic [31:0] model_pc;
    bit          done;

    pc_next_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_word (instr_word),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .pc_now     (pc_now),
        .redirect   (redirect)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Reference: next address and taken flag from the requirements.
    function automatic logic [31:0] ref_next(input logic [31:0] pc,
                                             input logic [31:0] iw,
                                             input logic [31:0] a,
                                             input logic [31:0] b,
                                             output bit tk);
        logic [31:0] nxt;
        int          words;
        nxt   = pc + 32'd4;
        words = int'($signed(iw[15:0]));
        tk    = 1'b0;
        if (iw[31:26] == 6'd2) begin
            tk = 1'b1;
            return {nxt[31:28], iw[25:0], 2'b00};
        end
        if ((iw[31:26] == 6'd4 && a == b) || (iw[31:26] == 6'd5 && a != b)) begin
            tk = 1'b1;
            return nxt + 32'(words * 4);
        end
        return nxt;
    endfunction

    // One instruction: drive after a falling edge, check flag, then address.
    task automatic step(input string tag, input logic [31:0] iw,
                        input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp;
        bit          tk;
        instr_word = iw;
        opnd_a     = a;
        opnd_b     = b;
        exp        = ref_next(model_pc, iw, a, b, tk);
        #1;
        check1({tag, " redirect R9"}, redirect, tk);
        @(negedge clk);
        check32({tag, " pc"}, pc_now, exp);
        check1({tag, " align R10"}, pc_now[1] | pc_now[0], 1'b0);
        model_pc = exp;
    endtask

    function automatic logic [31:0] mk_br(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd9, 5'd10, imm};
    endfunction

    function automatic logic [31:0] mk_j(input logic [25:0] fld);
        return {6'd2, fld};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        n_checks   = 0;
        n_fails    = 0;
        done       = 1'b0;
        rst_n      = 1'b0;
        instr_word = mk_br(6'd4, 16'd3);
        opnd_a     = 32'd1;
        opnd_b     = 32'd1;
        model_pc   = '0;
        repeat (3) @(negedge clk);
        check32("R1 reset pc", pc_now, 32'h0);
        check1("R1 reset redirect", redirect, 1'b0);
        rst_n = 1'b1;

        step("R2 R8 alu word", 32'h012A4020, 32'd5, 32'd6);
        step("R8 load word equal ops", {6'h23, 26'h1330004}, 32'd7, 32'd7);
        step("R3 beq taken", mk_br(6'd4, 16'd3), 32'hAA, 32'hAA);
        step("R5 beq not taken", mk_br(6'd4, 16'd3), 32'hAA, 32'hAB);
        step("R4 R6 bne taken max fwd", mk_br(6'd5, 16'h7FFF), 32'd1, 32'd2);
        step("R5 bne not taken", mk_br(6'd5, 16'h7FFF), 32'd3, 32'd3);
        step("R6 beq backward", mk_br(6'd4, 16'hFFF7), 32'd0, 32'd0);
        check32("R3 R6 backward lands", model_pc, 32'h00020000);
        step("R7 jump 80000", mk_j(26'd20000), 32'd1, 32'd2);
        check32("R7 jump byte addr", pc_now, 32'd80000);
        step("R7 jump region end", mk_j(26'h3FFFFFF), 32'd0, 32'd0);
        check32("R7 at region end", pc_now, 32'h0FFFFFFC);
        step("R7 jump region carry", mk_j(26'd5), 32'd0, 32'd0);
        check32("R7 region carry", pc_now, 32'h10000014);
        step("R6 beq min offset", mk_br(6'd4, 16'h8000), 32'd9, 32'd9);
        step("R7 jump low", mk_j(26'd4), 32'd0, 32'd1);
        step("R11 R6 wrap below zero", mk_br(6'd4, 16'h8000), 32'd2, 32'd2);
        check32("R11 wrapped addr", pc_now, 32'hFFFE0014);
        step("R2 seq high", 32'h0, 32'd0, 32'd0);
        step("R11 R7 jump region F", mk_j(26'd1), 32'd0, 32'd0);
        check32("R11 region F jump", pc_now, 32'hF0000004);

        // R1: reset during a taken branch wins over it
        instr_word = mk_br(6'd4, 16'd8);
        opnd_a     = 32'd4;
        opnd_b     = 32'd4;
        rst_n      = 1'b0;
        #1;
        check1("R1 redirect low in reset", redirect, 1'b0);
        @(negedge clk);
        check32("R1 mid-run reset", pc_now, 32'h0);
        model_pc = '0;
        rst_n    = 1'b1;

        for (int i = 0; i < 600; i++) begin
            logic [31:0] iw;
            logic [31:0] a;
            logic [31:0] b;
            int          kind;
            kind = $urandom_range(0, 7);
            a    = $urandom;
            b    = $urandom_range(0, 1) ? a : 32'($urandom);
            case (kind)
                0, 1: begin
                    iw = $urandom;
                    if (iw[31:26] == 6'd2 || iw[31:26] == 6'd4 || iw[31:26] == 6'd5)
                        iw[31:26] = 6'd8;
                end
                2:       iw = mk_j(26'($urandom));
                3, 4:    iw = mk_br(6'd4, 16'($urandom));
                5, 6:    iw = mk_br(6'd5, 16'($urandom));
                default: iw = {6'd0, 26'($urandom)};
            endcase
            step("R2 R3 R4 R7 R8 random", iw, a, b);
        end

        done = 1'b1;
        finish_run();
    end

endmodule